// File: doc/BRIEF.md
# Register-Mapped CRC Front End

This block sits between a simple memory-mapped bus and a CRC calculator. Software writes data words, half-words or bytes into a single shared data/result register. Each write is folded into the running CRC, one byte per clock cycle. Reading that same register returns the running result. A second write that arrives while the calculator is still busy is parked in a one-entry input buffer. A write beyond that stalls the bus until space frees up.

The unit also holds a scratch register, a control register, a programmable start value and a programmable generator polynomial. The control register selects the polynomial width, the granularity of bit reversal applied to incoming data, and whether the readout is mirrored. It also has a self-clearing bit that restarts the calculation from the start value. Writing the start value restarts the calculation as well.

Top module: `crc_fe_top`

## Requirements
- R1: After reset the registers read as follows. Data at offset 0x00 reads 0xFFFFFFFF. Scratch at 0x04 reads 0. Control at 0x08 reads 0. Start value at 0x10 reads 0xFFFFFFFF. Polynomial at 0x14 reads 0x04C11DB7.
- R2: A data write at 0x00 feeds 1, 2 or 4 bytes to the calculator, set by bus_size: 0 takes wdata[7:0], 1 takes wdata[15:0], and 2 or 3 take all 32 bits. The more significant byte goes first and each byte is taken MSB first. Each bit updates the CRC as follows: feedback = crc[width-1] xor bit; crc = crc shifted left by one, masked to the width; if the feedback is set, crc is xored with the polynomial. One byte is processed per cycle.
- R3: Control bits [4:3] set the polynomial width: 00 gives 32, 01 gives 16, 10 gives 8, 11 gives 7. A narrower result is read from the low bits of the data register.
- R4: Control bits [6:5] set the input bit reversal. 00 is none, 01 mirrors within each byte, 10 within each half-word, 11 across the whole word. For example, 0x1A2B3C4D becomes 0x58D43CB2, 0xD458B23C or 0xB23CD458. The granularity is limited to the access width, so a byte write with 11 mirrors only that byte.
- R5: Control bit 7 mirrors all 32 bits of the data register readout. For example, 0x11223344 reads as 0x22CC4488.
- R6: A word write to control with bit 0 set discards any item in flight or buffered and loads the CRC from the start value. Bit 0 always reads back as 0.
- R7: A word write to the start value register stores it and immediately loads it into the CRC.
- R8: The scratch register keeps its value through a control reset bit. Sub-word writes to any register other than data have no effect.
- R9: A data write is accepted with no wait state while the buffer is empty, even if the calculator is busy.
- R10: A data write that arrives while the buffer is full and the calculator is busy holds bus_ready low until the buffer drains.
- R11: A data register read holds bus_ready low until the calculator is idle and the buffer is empty, so it returns the final CRC.
- R12: A change of polynomial or width takes effect only for items that start after the change; an item already being processed completes with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Transfer request, held until bus_ready is seen high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2/3 word |
| bus_wdata | input | 32 | Write data, right-aligned for sub-word accesses |
| bus_ready | output | 1 | Transfer completes on the rising edge where sel and ready are both high |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high on a read |

## Verification
The hardest state to reach is one with the calculator busy and the buffer full at the same time, since that is when a third data write must stall. The stimulus reaches it by driving three word writes back to back, with no idle cycle between them. The bench measures the wait states of the second and third writes. Other checks rely on exact timing. One changes the polynomial width in the cycle after a word write is accepted, so the change lands while that word is being processed. Another issues a restart while an item is still in flight. A read then shows which settings were applied.

// File: rtl/crc_fe_pkg.sv
package crc_fe_pkg;

   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      ACC_BYTE = 2'd0,
      ACC_HALF = 2'd1,
      ACC_WORD = 2'd2,
      ACC_WIDE = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      PW_32 = 2'd0,
      PW_16 = 2'd1,
      PW_8  = 2'd2,
      PW_7  = 2'd3
   } poly_width_e;

   typedef enum logic [1:0] {
      RV_NONE = 2'd0,
      RV_BYTE = 2'd1,
      RV_HALF = 2'd2,
      RV_WORD = 2'd3
   } rev_mode_e;

   localparam logic [7:0] OFS_DATA    = 8'h00;
   localparam logic [7:0] OFS_SCRATCH = 8'h04;
   localparam logic [7:0] OFS_CTRL    = 8'h08;
   localparam logic [7:0] OFS_INIT    = 8'h10;
   localparam logic [7:0] OFS_POLY    = 8'h14;

   // Control field positions
   localparam int unsigned CB_RESTART = 0;
   localparam int unsigned CB_PW_LO   = 3;
   localparam int unsigned CB_RV_LO   = 5;
   localparam int unsigned CB_MIRROR  = 7;

   typedef struct packed {
      logic [WORD_W-1:0] data;
      logic [2:0]        nbytes;
   } crc_item_t;

   function automatic logic [WORD_W-1:0] pw_mask(poly_width_e pw);
      case (pw)
         PW_16:   return 32'h0000_FFFF;
         PW_8:    return 32'h0000_00FF;
         PW_7:    return 32'h0000_007F;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic int unsigned pw_msb(poly_width_e pw);
      case (pw)
         PW_16:   return 15;
         PW_8:    return 7;
         PW_7:    return 6;
         default: return 31;
      endcase
   endfunction

   // One byte, MSB first, through a left-shifting divider of selectable width
   function automatic logic [WORD_W-1:0] crc_step_byte(
      logic [WORD_W-1:0] c_in,
      logic [7:0]        d,
      logic [WORD_W-1:0] poly,
      poly_width_e       pw
   );
      logic [WORD_W-1:0] c;
      logic [WORD_W-1:0] m;
      logic              fb;
      int unsigned       top;
      c   = c_in;
      m   = pw_mask(pw);
      top = pw_msb(pw);
      for (int i = 7; i >= 0; i--) begin
         fb = c[top] ^ d[i];
         c  = (c << 1) & m;
         if (fb) c = c ^ (poly & m);
      end
      return c;
   endfunction

endpackage

// File: rtl/crc_fe_bitrev.sv
module crc_fe_bitrev
   import crc_fe_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] din,
   input  rev_mode_e    mode,
   output logic [W-1:0] dout
);

   localparam int unsigned LANE_B = 8;
   localparam int unsigned LANE_H = 16;

   if ((W % LANE_H) != 0) begin : g_w_chk
      $error("crc_fe_bitrev: W must be a multiple of 16");
   end

   logic [W-1:0] mir_b;
   logic [W-1:0] mir_h;
   logic [W-1:0] mir_w;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign mir_w[i] = din[W-1-i];
      assign mir_b[i] = din[(i/LANE_B)*LANE_B + LANE_B-1 - (i%LANE_B)];
      assign mir_h[i] = din[(i/LANE_H)*LANE_H + LANE_H-1 - (i%LANE_H)];
   end

   always_comb begin
      case (mode)
         RV_BYTE: dout = mir_b;
         RV_HALF: dout = mir_h;
         RV_WORD: dout = mir_w;
         default: dout = din;
      endcase
   end

endmodule

// File: rtl/crc_fe_inbuf.sv
module crc_fe_inbuf
   import crc_fe_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      flush,
   input  logic      push,
   input  crc_item_t push_item,
   input  logic      pop,
   output logic      full,
   output crc_item_t item
);

   logic      full_q;
   crc_item_t item_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else if (flush) begin
         full_q <= 1'b0;
      end else if (push) begin
         full_q <= 1'b1;
      end else if (pop) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         item_q <= '0;
      end else if (push) begin
         item_q <= push_item;
      end
   end

   assign full = full_q;
   assign item = item_q;

endmodule

// File: rtl/crc_fe_engine.sv
module crc_fe_engine
   import crc_fe_pkg::*;
#(
   parameter logic [WORD_W-1:0] CRC_RST = 32'hFFFF_FFFF,
   parameter int unsigned       CNT_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reinit,
   input  logic [WORD_W-1:0] reinit_val,
   input  logic              load,
   input  crc_item_t         ld_item,
   input  logic [WORD_W-1:0] ld_poly,
   input  poly_width_e       ld_pw,
   output logic [WORD_W-1:0] crc,
   output logic              busy
);

   localparam int unsigned MAX_BYTES = WORD_W / 8;

   if ((1 << CNT_W) <= MAX_BYTES) begin : g_cnt_chk
      $error("crc_fe_engine: CNT_W too small for the byte count");
   end

   logic [WORD_W-1:0] crc_q;
   logic [WORD_W-1:0] dat_q;
   logic [WORD_W-1:0] poly_q;
   poly_width_e       pw_q;
   logic [CNT_W-1:0]  rem_q;

   logic [1:0]        cur_idx;
   logic [WORD_W-1:0] cur_dat;
   logic [7:0]        cur_byte;
   logic [WORD_W-1:0] cur_poly;
   poly_width_e       cur_pw;
   logic [WORD_W-1:0] crc_nxt;

   // Settings are snapshotted when an item starts
   always_comb begin
      if (load) begin
         cur_idx  = 2'(ld_item.nbytes - 3'd1);
         cur_dat  = ld_item.data;
         cur_poly = ld_poly;
         cur_pw   = ld_pw;
      end else begin
         cur_idx  = 2'(rem_q - CNT_W'(1));
         cur_dat  = dat_q;
         cur_poly = poly_q;
         cur_pw   = pw_q;
      end
      cur_byte = cur_dat[{cur_idx, 3'b000} +: 8];
      crc_nxt  = crc_step_byte(crc_q, cur_byte, cur_poly, cur_pw);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc_q  <= CRC_RST;
         rem_q  <= '0;
         dat_q  <= '0;
         poly_q <= '0;
         pw_q   <= PW_32;
      end else if (reinit) begin
         crc_q <= reinit_val;
         rem_q <= '0;
      end else if (load) begin
         crc_q  <= crc_nxt;
         rem_q  <= CNT_W'(ld_item.nbytes - 3'd1);
         dat_q  <= ld_item.data;
         poly_q <= ld_poly;
         pw_q   <= ld_pw;
      end else if (rem_q != '0) begin
         crc_q <= crc_nxt;
         rem_q <= rem_q - CNT_W'(1);
      end
   end

   assign crc  = crc_q;
   assign busy = (rem_q != '0);

endmodule

// File: rtl/crc_fe_top.sv
module crc_fe_top
   import crc_fe_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 5,
   parameter logic [WORD_W-1:0] INIT_RST = 32'hFFFF_FFFF,
   parameter logic [WORD_W-1:0] POLY_RST = 32'h04C1_1DB7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [31:0]       bus_wdata,
   output logic              bus_ready,
   output logic [31:0]       bus_rdata
);

   if (ADDR_W < 5 || ADDR_W > 8) begin : g_addr_chk
      $error("crc_fe_top: ADDR_W must be between 5 and 8");
   end

   localparam logic [ADDR_W-1:0] A_DATA    = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_SCRATCH = ADDR_W'(OFS_SCRATCH);
   localparam logic [ADDR_W-1:0] A_CTRL    = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_INIT    = ADDR_W'(OFS_INIT);
   localparam logic [ADDR_W-1:0] A_POLY    = ADDR_W'(OFS_POLY);

   // ---------------- decode ----------------
   acc_size_e acc;
   logic      acc_word;
   logic      hit_data, hit_scratch, hit_ctrl, hit_init, hit_poly;

   assign acc         = acc_size_e'(bus_size);
   assign acc_word    = bus_size[1];
   assign hit_data    = (bus_addr == A_DATA);
   assign hit_scratch = (bus_addr == A_SCRATCH);
   assign hit_ctrl    = (bus_addr == A_CTRL);
   assign hit_init    = (bus_addr == A_INIT);
   assign hit_poly    = (bus_addr == A_POLY);

   // ---------------- registers ----------------
   logic [WORD_W-1:0] scratch_q;
   logic [WORD_W-1:0] init_q;
   logic [WORD_W-1:0] poly_q;
   poly_width_e       pw_q;
   rev_mode_e         rv_q;
   logic              mirror_q;

   // ---------------- datapath wiring ----------------
   logic              eng_busy;
   logic [WORD_W-1:0] eng_crc;
   logic              buf_full;
   crc_item_t         buf_item;
   crc_item_t         in_item;
   crc_item_t         eng_item;
   logic              eng_load;
   logic              buf_push, buf_pop;
   logic              reinit;
   logic [WORD_W-1:0] reinit_val;

   logic data_wr_rq, data_rd_rq, data_wr_go, cfg_wr;

   assign data_wr_rq = bus_sel &  bus_wr & hit_data;
   assign data_rd_rq = bus_sel & ~bus_wr & hit_data;

   always_comb begin
      if (data_wr_rq)      bus_ready = ~buf_full | ~eng_busy;
      else if (data_rd_rq) bus_ready = ~buf_full & ~eng_busy;
      else                 bus_ready = 1'b1;
   end

   assign data_wr_go = data_wr_rq & bus_ready;
   assign cfg_wr     = bus_sel & bus_wr & acc_word;

   // ---------------- incoming item ----------------
   logic [WORD_W-1:0] in_mask;
   logic [2:0]        in_nbytes;
   rev_mode_e         rv_lim;
   rev_mode_e         rv_eff;
   logic [WORD_W-1:0] in_rev;

   always_comb begin
      case (acc)
         ACC_BYTE: begin in_mask = 32'h0000_00FF; in_nbytes = 3'd1; rv_lim = RV_BYTE; end
         ACC_HALF: begin in_mask = 32'h0000_FFFF; in_nbytes = 3'd2; rv_lim = RV_HALF; end
         default:  begin in_mask = 32'hFFFF_FFFF; in_nbytes = 3'd4; rv_lim = RV_WORD; end
      endcase
      rv_eff = (rv_q > rv_lim) ? rv_lim : rv_q;
   end

   crc_fe_bitrev #(.W(WORD_W)) u_rev_in (
      .din  (bus_wdata & in_mask),
      .mode (rv_eff),
      .dout (in_rev)
   );

   assign in_item.data   = in_rev;
   assign in_item.nbytes = in_nbytes;

   // ---------------- buffer / engine hand-off ----------------
   assign eng_load = ~eng_busy & (buf_full | data_wr_go);
   assign eng_item = buf_full ? buf_item : in_item;
   assign buf_pop  = ~eng_busy & buf_full;
   assign buf_push = data_wr_go & ~(~eng_busy & ~buf_full);

   assign reinit     = cfg_wr & ((hit_ctrl & bus_wdata[CB_RESTART]) | hit_init);
   assign reinit_val = hit_init ? bus_wdata : init_q;

   crc_fe_inbuf u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (reinit),
      .push      (buf_push),
      .push_item (in_item),
      .pop       (buf_pop),
      .full      (buf_full),
      .item      (buf_item)
   );

   crc_fe_engine #(.CRC_RST(INIT_RST), .CNT_W(3)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .reinit     (reinit),
      .reinit_val (reinit_val),
      .load       (eng_load),
      .ld_item    (eng_item),
      .ld_poly    (poly_q),
      .ld_pw      (pw_q),
      .crc        (eng_crc),
      .busy       (eng_busy)
   );

   // ---------------- configuration registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scratch_q <= '0;
         init_q    <= INIT_RST;
         poly_q    <= POLY_RST;
         pw_q      <= PW_32;
         rv_q      <= RV_NONE;
         mirror_q  <= 1'b0;
      end else if (cfg_wr) begin
         if (hit_scratch) scratch_q <= bus_wdata;
         if (hit_init)    init_q    <= bus_wdata;
         if (hit_poly)    poly_q    <= bus_wdata;
         if (hit_ctrl) begin
            pw_q     <= poly_width_e'(bus_wdata[CB_PW_LO +: 2]);
            rv_q     <= rev_mode_e'(bus_wdata[CB_RV_LO +: 2]);
            mirror_q <= bus_wdata[CB_MIRROR];
         end
      end
   end

   // ---------------- readout ----------------
   logic [WORD_W-1:0] crc_view;
   logic [WORD_W-1:0] ctrl_view;

   crc_fe_bitrev #(.W(WORD_W)) u_rev_out (
      .din  (eng_crc),
      .mode (mirror_q ? RV_WORD : RV_NONE),
      .dout (crc_view)
   );

   always_comb begin
      ctrl_view                    = '0;
      ctrl_view[CB_PW_LO +: 2]     = pw_q;
      ctrl_view[CB_RV_LO +: 2]     = rv_q;
      ctrl_view[CB_MIRROR]         = mirror_q;
   end

   always_comb begin
      if (hit_data)         bus_rdata = crc_view;
      else if (hit_scratch) bus_rdata = scratch_q;
      else if (hit_ctrl)    bus_rdata = ctrl_view;
      else if (hit_init)    bus_rdata = init_q;
      else if (hit_poly)    bus_rdata = poly_q;
      else                  bus_rdata = '0;
   end

endmodule

// File: rtl/crc_fe_checker.sv
module crc_fe_checker #(
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic [31:0]       bus_wdata,
   input logic              bus_ready,
   input logic              eng_busy,
   input logic              buf_full,
   input logic [31:0]       crc_val,
   input logic [31:0]       init_val,
   input logic [31:0]       scratch_val
);

   logic at_data, at_scr, at_ctrl, at_init, wordsz;
   assign at_data = (bus_addr == ADDR_W'(8'h00));
   assign at_scr  = (bus_addr == ADDR_W'(8'h04));
   assign at_ctrl = (bus_addr == ADDR_W'(8'h08));
   assign at_init = (bus_addr == ADDR_W'(8'h10));
   assign wordsz  = bus_size[1];

   p_read_final_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && at_data && bus_ready) |-> (!eng_busy && !buf_full));

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && at_data && buf_full && eng_busy) |-> !bus_ready);

   p_no_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && at_data && !buf_full) |-> bus_ready);

   p_init_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && at_init && wordsz && bus_ready) |=> (crc_val == $past(bus_wdata)));

   p_restart_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && at_ctrl && wordsz && bus_wdata[0] && bus_ready)
      |=> (!eng_busy && !buf_full && crc_val == init_val));

   p_scratch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr && at_scr && wordsz) |=> $stable(scratch_val));

endmodule

bind crc_fe_top crc_fe_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .bus_size    (bus_size),
   .bus_wdata   (bus_wdata),
   .bus_ready   (bus_ready),
   .eng_busy    (eng_busy),
   .buf_full    (buf_full),
   .crc_val     (eng_crc),
   .init_val    (init_q),
   .scratch_val (scratch_q)
);

// File: tb/crc_fe_top_test.sv
`timescale 1ns/1ps
module crc_fe_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [1:0]  bus_size = 2'd2;
   logic [31:0] bus_wdata = '0;
   logic        bus_ready;
   logic [31:0] bus_rdata;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   crc_fe_top uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wdata (bus_wdata),
      .bus_ready (bus_ready),
      .bus_rdata (bus_rdata)
   );

   // ---------------- scoreboard ----------------
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] mon_e;
   string       mon_t;

   always begin
      @(negedge clk);
      if (bus_sel && !bus_wr && bus_ready) begin
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected read: actual %h expected none", bus_rdata);
         end else begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            n_cmp++;
            if (bus_rdata !== mon_e) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", mon_t, bus_rdata, mon_e);
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [31:0] m_crc  = 32'hFFFF_FFFF;
   logic [31:0] m_init = 32'hFFFF_FFFF;
   logic [31:0] m_poly = 32'h04C1_1DB7;
   int          m_wid  = 32;

   function automatic logic [31:0] ref_crc(logic [31:0] c, logic [31:0] d, int nb,
                                           logic [31:0] poly, int wid);
      logic [31:0] msk;
      logic        hi;
      msk = (wid == 32) ? 32'hFFFF_FFFF : ((32'd1 << wid) - 32'd1);
      for (int b = nb - 1; b >= 0; b--) begin
         for (int i = 7; i >= 0; i--) begin
            hi = c[wid-1];
            c  = (c << 1) & msk;
            if (hi ^ d[8*b+i]) c = c ^ (poly & msk);
         end
      end
      return c;
   endfunction

   // ---------------- driver ----------------
   task automatic xfer(input logic w, input logic [4:0] a, input logic [1:0] sz,
                       input logic [31:0] d, output int waits);
      bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_size = sz; bus_wdata = d;
      waits = 0;
      @(negedge clk);
      while (!bus_ready) begin
         waits++;
         @(negedge clk);
      end
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic wr32(input logic [4:0] a, input logic [31:0] d);
      int w;
      xfer(1'b1, a, 2'd2, d, w);
   endtask

   // data write: eff is the value the calculator must see after input reversal
   task automatic put(input logic [1:0] sz, input logic [31:0] d, input logic [31:0] eff,
                      output int waits);
      int nb;
      nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      m_crc = ref_crc(m_crc, eff, nb, m_poly, m_wid);
      xfer(1'b1, 5'h00, sz, d, waits);
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag,
                     output int waits);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      xfer(1'b0, a, 2'd2, 32'h0, waits);
   endtask

   task automatic restart(input logic [31:0] ctrl_bits);
      wr32(5'h08, ctrl_bits | 32'h1);
      m_crc = m_init;
   endtask

   task automatic digits();
      int w;
      for (int k = 0; k < 9; k++) put(2'd0, 32'h31 + k, 32'h31 + k, w);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // ---------------- sequence ----------------
   initial begin
      int w, w2, w3;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset values
      rd(5'h00, 32'hFFFF_FFFF, "R1 data reset", w);
      rd(5'h04, 32'h0000_0000, "R1 scratch reset", w);
      rd(5'h08, 32'h0000_0000, "R1 ctrl reset", w);
      rd(5'h10, 32'hFFFF_FFFF, "R1 init reset", w);
      rd(5'h14, 32'h04C1_1DB7, "R1 poly reset", w);

      // R2 byte stream of "123456789", known check value
      digits();
      rd(5'h00, 32'h0376_E6E7, "R2 byte check value", w);
      chk("R2 model agrees", m_crc, 32'h0376_E6E7);

      // R6 restart bit
      restart(32'h0);
      rd(5'h00, 32'hFFFF_FFFF, "R6 restart loads init", w);
      rd(5'h08, 32'h0000_0000, "R6 restart bit reads zero", w);

      // R2 mixed sizes give the same value; R9 second write without wait; R11 read hold
      put(2'd2, 32'h3132_3334, 32'h3132_3334, w);
      put(2'd1, 32'h0000_3536, 32'h0000_3536, w2);
      chk("R9 second write no wait", 32'(w2), 32'd0);
      put(2'd1, 32'hAAAA_3738, 32'h0000_3738, w);
      put(2'd0, 32'hFFFF_FF39, 32'h0000_0039, w);
      rd(5'h00, 32'h0376_E6E7, "R2 mixed sizes check value", w3);
      chk("R11 read held while busy", 32'(w3 > 0), 32'd1);

      // R10 third back-to-back word stalls
      restart(32'h0);
      put(2'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, w);
      put(2'd2, 32'h0123_4567, 32'h0123_4567, w2);
      put(2'd2, 32'h89AB_CDEF, 32'h89AB_CDEF, w3);
      chk("R9 buffered write no wait", 32'(w2), 32'd0);
      chk("R10 full buffer stalls", 32'(w3 > 0), 32'd1);
      rd(5'h00, m_crc, "R10 result after stall", w);

      // R7 init write reloads; R5 output mirror
      wr32(5'h10, 32'h1122_3344);
      m_init = 32'h1122_3344;
      rd(5'h00, 32'h1122_3344, "R7 init write reloads", w);
      wr32(5'h08, 32'h0000_0080);
      rd(5'h00, 32'h22CC_4488, "R5 mirrored readout", w);
      wr32(5'h08, 32'h0000_0000);

      // R4 input reversal modes
      wr32(5'h10, 32'hFFFF_FFFF);
      m_init = 32'hFFFF_FFFF;
      restart(32'h20);
      put(2'd2, 32'h1A2B_3C4D, 32'h58D4_3CB2, w);
      rd(5'h00, m_crc, "R4 reverse by byte", w);
      restart(32'h40);
      put(2'd2, 32'h1A2B_3C4D, 32'hD458_B23C, w);
      rd(5'h00, m_crc, "R4 reverse by half-word", w);
      restart(32'h60);
      put(2'd2, 32'h1A2B_3C4D, 32'hB23C_D458, w);
      rd(5'h00, m_crc, "R4 reverse by word", w);
      restart(32'h60);
      put(2'd0, 32'h0000_0001, 32'h0000_0080, w);
      rd(5'h00, m_crc, "R4 byte access clips word reversal", w);

      // R3 polynomial widths with known check values
      wr32(5'h14, 32'h0000_1021);
      wr32(5'h10, 32'h0000_FFFF);
      m_poly = 32'h1021; m_init = 32'hFFFF; m_wid = 16;
      restart(32'h08);
      digits();
      rd(5'h00, 32'h0000_29B1, "R3 width 16", w);
      wr32(5'h14, 32'h0000_0007);
      wr32(5'h10, 32'h0000_0000);
      m_poly = 32'h07; m_init = 32'h0; m_wid = 8;
      restart(32'h10);
      digits();
      rd(5'h00, 32'h0000_00F4, "R3 width 8", w);
      wr32(5'h14, 32'h0000_0009);
      m_poly = 32'h09; m_wid = 7;
      restart(32'h18);
      digits();
      rd(5'h00, 32'h0000_0075, "R3 width 7", w);

      // R12 width change while a word is in flight
      wr32(5'h14, 32'h04C1_1DB7);
      wr32(5'h10, 32'hFFFF_FFFF);
      m_poly = 32'h04C1_1DB7; m_init = 32'hFFFF_FFFF; m_wid = 32;
      restart(32'h0);
      put(2'd2, 32'h3132_3334, 32'h3132_3334, w);
      wr32(5'h08, 32'h0000_0010);
      rd(5'h00, m_crc, "R12 in-flight item keeps old width", w);
      wr32(5'h08, 32'h0000_0000);

      // R8 scratch survives restart, sub-word writes ignored
      wr32(5'h04, 32'hCAFE_F00D);
      restart(32'h0);
      rd(5'h04, 32'hCAFE_F00D, "R8 scratch through restart", w);
      xfer(1'b1, 5'h04, 2'd0, 32'h0000_0011, w);
      rd(5'h04, 32'hCAFE_F00D, "R8 byte write to scratch ignored", w);
      xfer(1'b1, 5'h14, 2'd1, 32'h0000_1234, w);
      rd(5'h14, 32'h04C1_1DB7, "R8 half write to poly ignored", w);

      // R6 restart discards items in flight and buffered
      put(2'd2, 32'h5555_AAAA, 32'h5555_AAAA, w);
      put(2'd2, 32'h7777_8888, 32'h7777_8888, w);
      restart(32'h0);
      rd(5'h00, 32'hFFFF_FFFF, "R6 restart flushes pending work", w);

      repeat (4) @(posedge clk);
      chk("scoreboard drained", 32'(exp_q.size()), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule